// File: doc/BRIEF.md
# Serial Port Reset Detector and Output Sequencer

This block is the device-side front end of a sensor's serial port. A free-running system clock samples the chip-select, serial-clock and data-in pins through synchronizer stages. The host can request a hardware reset by holding chip select low and serial clock high for a fixed hold time. The block then emits a one-cycle internal reset request, and the rest of the chip takes that request as its reset.

After any reset, either the external synchronous reset or the pin-requested one, the data output goes through three phases. It first floats for an 800 µs quiet window. It is then driven high for a 3 ms settling window. Only after that does normal operation begin, and a ready status goes high at that point. In normal operation the output enable follows chip select. Input bits are shifted in on serial clock rising edges. The outgoing word carries a reset-occurred flag in its first bit, so the host can notice a reset it did not expect. The flag clears once one complete transfer, started after the settling window, has carried it out.

All time windows are derived from a clock frequency parameter and rounded to whole cycles. A divide parameter shrinks them for short test runs.

Top module: `spi_rst_seq`

## Requirements
- R1: While `rst` is high, `dout_oe_o`, `ready_o`, `rst_req_o` and `rx_valid_o` are all 0.
- R2: When the synchronized chip select is low and the synchronized serial clock is high for HOLD_CYC consecutive cycles (512 µs), `rst_req_o` pulses high for exactly one cycle. It appears HOLD_CYC+2 cycles after the pins first take that state. It does not repeat while the pins stay in that state, and it restarts the output sequence.
- R3: A single sampled cycle in which either condition is false clears the hold count, so a full HOLD_CYC run is needed again.
- R4: For HIZ_CYC cycles (800 µs) after reset, `dout_oe_o` is 0 whatever chip select does.
- R5: For the next STAB_CYC cycles (3 ms), `dout_oe_o` is 1 and `dout_o` is 1 with `ready_o` low. After that, `ready_o` is 1.
- R6: Once ready, `dout_oe_o` is 1 while chip select is low and 0 while it is high, lagging the pin by the synchronizer delay.
- R7: Within a chip-select-low frame, `din_i` is sampled on each serial clock rising edge, most significant bit first. After FRAME_W rising edges, `rx_valid_o` pulses for one cycle with the FRAME_W-bit word on `rx_data_o`.
- R8: A frame that begins before `ready_o` is high produces no `rx_valid_o` pulse.
- R9: Once ready, `dout_o` presents the word {reset flag, `tx_payload_i`} most significant bit first. The first bit is valid after chip select falls, and each following bit is valid after a serial clock falling edge.
- R10: The reset flag (first output bit) is 1 after any reset. It clears after the first complete frame that began while ready, so the next frame shows 0.
- R11: Raising chip select mid-frame discards the partial bit count, and the next frame is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| din_i | input | 1 | Serial data input pin |
| tx_payload_i | input | FRAME_W-1 | Bits sent after the reset flag |
| dout_o | output | 1 | Serial data output value |
| dout_oe_o | output | 1 | Output enable for the data pin driver |
| ready_o | output | 1 | High once the settling window has ended |
| rst_req_o | output | 1 | One-cycle internal reset request |
| rx_data_o | output | FRAME_W | Last received word |
| rx_valid_o | output | 1 | Pulse when a received word is complete |

## Verification
The reset detector is exercised three ways. An uninterrupted hold has its latency measured exactly. A hold broken by a one-cycle serial clock dip shows that the count restarts rather than resumes. A hold extended past the trigger shows that no second pulse follows. The shift path is walked through a table of payload and input words with differing bit patterns, which separates bit order, flag placement and flag clearing. Directed frames sent during the settling window, and an aborted partial frame, separate the gating of received words by ready from the clearing of the bit count on chip select.

// File: rtl/spi_rst_seq_pkg.sv
package spi_rst_seq_pkg;

    typedef enum logic [1:0] {
        PH_HIZ  = 2'd0,
        PH_STAB = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
    } pin_s;

    localparam int unsigned HOLD_US = 512;
    localparam int unsigned HIZ_US  = 800;
    localparam int unsigned STAB_US = 3000;

    // Rounded cycle count for a duration in microseconds, scaled down by div.
    function automatic int unsigned us_to_cycles(int unsigned clk_hz,
                                                 int unsigned us,
                                                 int unsigned div);
        longint unsigned num;
        longint unsigned den;
        longint unsigned q;
        den = 64'(div) * 64'd1_000_000;
        num = 64'(clk_hz) * 64'(us) + den / 64'd2;
        q   = num / den;
        if (q == 64'd0) q = 64'd1;
        return q[31:0];
    endfunction

    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srs_hold_det.sv
module srs_hold_det #(
    parameter int unsigned HOLD_CYC = 128,
    localparam int unsigned CW      = spi_rst_seq_pkg::width_for(HOLD_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    output logic          req_o,
    output logic [CW-1:0] cnt_o
);
    logic          cond;
    logic [CW-1:0] cnt_q;
    logic          req_q;

    assign cond = !cs_n_s && sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= cond && (cnt_q == CW'(HOLD_CYC - 1));
            if (!cond) begin
                cnt_q <= '0;
            end else if (cnt_q != CW'(HOLD_CYC)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign req_o = req_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/srs_phase_seq.sv
module srs_phase_seq
    import spi_rst_seq_pkg::*;
#(
    parameter int unsigned HIZ_CYC  = 200,
    parameter int unsigned STAB_CYC = 750,
    localparam int unsigned MAXC    = (HIZ_CYC > STAB_CYC) ? HIZ_CYC : STAB_CYC,
    localparam int unsigned TW      = width_for(MAXC)
) (
    input  logic   clk,
    input  logic   rst_i,
    output phase_e phase_o
);
    phase_e        ph_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst_i) begin
            ph_q  <= PH_HIZ;
            tmr_q <= '0;
        end else begin
            unique case (ph_q)
                PH_HIZ: begin
                    if (tmr_q == TW'(HIZ_CYC - 1)) begin
                        ph_q  <= PH_STAB;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_STAB: begin
                    if (tmr_q == TW'(STAB_CYC - 1)) begin
                        ph_q  <= PH_RUN;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    ph_q  <= PH_RUN;
                    tmr_q <= '0;
                end
            endcase
        end
    end

    assign phase_o = ph_q;
endmodule

// File: rtl/srs_shift.sv
module srs_shift #(
    parameter int unsigned FRAME_W = 8,
    localparam int unsigned BW     = spi_rst_seq_pkg::width_for(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_i,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               din_s,
    input  logic               ready_i,
    input  logic               flag_i,
    input  logic [FRAME_W-2:0] payload_i,
    output logic               dout_bit_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               rx_valid_o
);
    logic               sclk_d, cs_d;
    logic               sclk_rise, sclk_fall, cs_fall;
    logic [FRAME_W-1:0] tx_sr, rx_sr, rx_word;
    logic [BW-1:0]      bit_cnt;
    logic               armed;
    logic               rx_valid_q;
    logic [FRAME_W-1:0] rx_data_q;

    assign sclk_rise = sclk_s && !sclk_d;
    assign sclk_fall = !sclk_s && sclk_d;
    assign cs_fall   = !cs_n_s && cs_d;
    assign rx_word   = {rx_sr[FRAME_W-2:0], din_s};

    always_ff @(posedge clk) begin
        if (rst_i) begin
            sclk_d     <= 1'b0;
            cs_d       <= 1'b1;
            tx_sr      <= '0;
            rx_sr      <= '0;
            bit_cnt    <= '0;
            armed      <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            sclk_d     <= sclk_s;
            cs_d       <= cs_n_s;
            rx_valid_q <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                armed   <= 1'b0;
            end else begin
                if (cs_fall) begin
                    tx_sr <= {flag_i, payload_i};
                    armed <= ready_i;
                end else if (sclk_fall) begin
                    tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                end
                if (sclk_rise) begin
                    rx_sr <= rx_word;
                    if (bit_cnt == BW'(FRAME_W - 1)) begin
                        bit_cnt <= '0;
                        if (armed) begin
                            rx_valid_q <= 1'b1;
                            rx_data_q  <= rx_word;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign dout_bit_o = tx_sr[FRAME_W-1];
    assign rx_data_o  = rx_data_q;
    assign rx_valid_o = rx_valid_q;
endmodule

// File: rtl/spi_rst_seq.sv
module spi_rst_seq
    import spi_rst_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned TIME_DIV    = 1,
    parameter int unsigned FRAME_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_i,
    input  logic               sclk_i,
    input  logic               din_i,
    input  logic [FRAME_W-2:0] tx_payload_i,
    output logic               dout_o,
    output logic               dout_oe_o,
    output logic               ready_o,
    output logic               rst_req_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               rx_valid_o
);
    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US, TIME_DIV);
    localparam int unsigned HIZ_CYC  = us_to_cycles(CLK_HZ, HIZ_US, TIME_DIV);
    localparam int unsigned STAB_CYC = us_to_cycles(CLK_HZ, STAB_US, TIME_DIV);
    localparam int unsigned HCW      = width_for(HOLD_CYC);
    localparam int unsigned PW       = $bits(pin_s);
    localparam pin_s        PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0};

    pin_s            pin_raw, pin_q;
    logic [PW-1:0]   sync_vec;
    logic            hold_req;
    logic [HCW-1:0]  hold_cnt;
    logic            rst_int;
    phase_e          phase;
    logic            ready;
    logic            flag_q;
    logic            tx_bit;
    logic            rx_valid;

    assign pin_raw = '{cs_n: cs_n_i, sclk: sclk_i, din: din_i};

    srs_sync #(
        .W       (PW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_raw),
        .q_o (sync_vec)
    );

    assign pin_q = pin_s'(sync_vec);

    srs_hold_det #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (pin_q.cs_n),
        .sclk_s (pin_q.sclk),
        .req_o  (hold_req),
        .cnt_o  (hold_cnt)
    );

    assign rst_int = rst || hold_req;

    srs_phase_seq #(
        .HIZ_CYC  (HIZ_CYC),
        .STAB_CYC (STAB_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_i   (rst_int),
        .phase_o (phase)
    );

    assign ready = (phase == PH_RUN);

    srs_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_i      (rst_int),
        .cs_n_s     (pin_q.cs_n),
        .sclk_s     (pin_q.sclk),
        .din_s      (pin_q.din),
        .ready_i    (ready),
        .flag_i     (flag_q),
        .payload_i  (tx_payload_i),
        .dout_bit_o (tx_bit),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid)
    );

    // Reset-occurred flag: set by any reset, cleared by a ready-armed frame.
    always_ff @(posedge clk) begin
        if (rst_int)       flag_q <= 1'b1;
        else if (rx_valid) flag_q <= 1'b0;
    end

    always_comb begin
        unique case (phase)
            PH_HIZ: begin
                dout_o    = 1'b0;
                dout_oe_o = 1'b0;
            end
            PH_STAB: begin
                dout_o    = 1'b1;
                dout_oe_o = 1'b1;
            end
            default: begin
                dout_o    = tx_bit;
                dout_oe_o = !pin_q.cs_n;
            end
        endcase
    end

    assign ready_o    = ready;
    assign rst_req_o  = hold_req;
    assign rx_valid_o = rx_valid;
endmodule

// File: rtl/spi_rst_seq_chk.sv
module spi_rst_seq_chk
    import spi_rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 128,
    parameter int unsigned HCW      = 8
) (
    input logic           clk,
    input logic           rst,
    input phase_e         phase,
    input logic           cs_s,
    input logic           sclk_s,
    input logic [HCW-1:0] hold_cnt,
    input logic           rst_req_o,
    input logic           ready_o,
    input logic           dout_o,
    input logic           dout_oe_o,
    input logic           rx_valid_o
);
    p_req_restarts_r2: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> (phase == PH_HIZ) && !ready_o);

    p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    p_break_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_s || !sclk_s) |=> (hold_cnt == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= HCW'(HOLD_CYC));

    p_hiz_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIZ) |-> !dout_oe_o);

    p_stab_high_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAB) |-> (dout_oe_o && dout_o && !ready_o));

    p_ready_after_stab_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(phase) == PH_STAB));

    p_valid_gated_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> ready_o);
endmodule

bind spi_rst_seq spi_rst_seq_chk #(
    .HOLD_CYC (HOLD_CYC),
    .HCW      (HCW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .cs_s       (pin_q.cs_n),
    .sclk_s     (pin_q.sclk),
    .hold_cnt   (hold_cnt),
    .rst_req_o  (rst_req_o),
    .ready_o    (ready_o),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sim_spi_rst_seq.sv
module sim_spi_rst_seq;
    localparam int TDIV   = 1000;
    localparam int HOLD_E = 250 * 512 / TDIV;   // 128
    localparam int HIZ_E  = 250 * 800 / TDIV;   // 200
    localparam int STAB_E = 250 * 3000 / TDIV;  // 750
    localparam int NVEC   = 6;
    // {payload[6:0], din word[7:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {7'h55, 8'hA5}, {7'h00, 8'hFF}, {7'h7F, 8'h00},
        {7'h2A, 8'h81}, {7'h41, 8'h3C}, {7'h1E, 8'h6B}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [6:0] payload = '0;
    logic       dout, dout_oe, ready, rst_req, rx_valid;
    logic [7:0] rx_data;

    int checks = 0, fails = 0, nvalid = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_rst_seq #(.CLK_HZ(250_000_000), .TIME_DIV(TDIV), .FRAME_W(8)) u0 (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .tx_payload_i(payload), .dout_o(dout), .dout_oe_o(dout_oe),
        .ready_o(ready), .rst_req_o(rst_req), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid)
    );

    always @(negedge clk) if (!rst && rx_valid) nvalid++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [6:0] pl, input logic [7:0] d, output logic [7:0] got);
        payload = pl;
        cs_n = 1'b0;
        sclk = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            din = d[b];
            wait_cyc(4);
            got[b] = dout;
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
        end
        wait_cyc(4);
        cs_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog req=none actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int n, v0;
        bit flag_e;

        // R1: reset state
        wait_cyc(5);
        check(!dout_oe && !ready && !rst_req && !rx_valid, "R1",
              {dout_oe, ready, rst_req, rx_valid}, 0);
        rst = 1'b0;

        // R4: quiet window length
        n = 0;
        while (!dout_oe && n < 5000) begin n++; wait_cyc(1); end
        check(n == HIZ_E, "R4 window", n, HIZ_E);

        // R5: driven-high settling window, then ready
        n = 0;
        while (dout_oe && dout && !ready && n < 5000) begin n++; wait_cyc(1); end
        check(n == STAB_E, "R5 window", n, STAB_E);
        check(ready == 1'b1, "R5 ready", ready, 1);

        // R6: output enable follows chip select
        cs_n = 1'b0; wait_cyc(4);
        check(dout_oe == 1'b1, "R6 low", dout_oe, 1);
        cs_n = 1'b1; wait_cyc(4);
        check(dout_oe == 1'b0, "R6 high", dout_oe, 0);

        // R7 R9 R10: vector table walk
        flag_e = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            v0 = nvalid;
            xfer(VEC[i][14:8], VEC[i][7:0], got);
            check(got == {flag_e, VEC[i][14:8]}, "R9 R10 dout word", got, {flag_e, VEC[i][14:8]});
            check(nvalid == v0 + 1, "R7 valid", nvalid - v0, 1);
            check(rx_data == VEC[i][7:0], "R7 data", rx_data, VEC[i][7:0]);
            flag_e = 1'b0;
        end

        // R11: aborted partial frame
        cs_n = 1'b0;
        for (int b = 0; b < 3; b++) begin
            din = 1'b1; wait_cyc(4); sclk = 1'b1; wait_cyc(4); sclk = 1'b0;
        end
        wait_cyc(4); cs_n = 1'b1; wait_cyc(6);
        v0 = nvalid;
        xfer(7'h11, 8'h5A, got);
        check(nvalid == v0 + 1, "R11 valid", nvalid - v0, 1);
        check(rx_data == 8'h5A, "R11 data", rx_data, 8'h5A);

        // R3: a one-cycle break restarts the hold count
        cs_n = 1'b0; sclk = 1'b1;
        n = 0;
        for (int c = 0; c < 100; c++) begin wait_cyc(1); if (rst_req) n++; end
        sclk = 1'b0; wait_cyc(1); sclk = 1'b1;
        check(n == 0, "R3 early", n, 0);
        n = 0;
        do begin wait_cyc(1); n++; end while (!rst_req && n < 1000);
        check(n == HOLD_E + 2, "R2 R3 latency", n, HOLD_E + 2);

        // R2: single pulse, sequence restarted; R4 with chip select low
        wait_cyc(1);
        check(!rst_req && !ready && !dout_oe, "R2 R4 after req",
              {rst_req, ready, dout_oe}, 0);
        n = 0;
        for (int c = 0; c < 40; c++) begin wait_cyc(1); if (rst_req) n++; end
        check(n == 0, "R2 no repeat", n, 0);
        check(dout_oe == 1'b0, "R4 cs low", dout_oe, 0);
        cs_n = 1'b1; sclk = 1'b0;

        // R8: frame during settling window is ignored
        n = 0;
        while (!dout_oe && n < 5000) begin n++; wait_cyc(1); end
        v0 = nvalid;
        xfer(7'h00, 8'hC3, got);
        check(got == 8'hFF, "R5 dout high", got, 8'hFF);
        check(nvalid == v0, "R8 no valid", nvalid - v0, 0);
        check(ready == 1'b0, "R8 not ready", ready, 0);

        // R10: flag set again by internal reset, then clears
        n = 0;
        while (!ready && n < 5000) begin n++; wait_cyc(1); end
        xfer(7'h33, 8'h99, got);
        check(got == {1'b1, 7'h33}, "R10 flag set", got, {1'b1, 7'h33});
        xfer(7'h33, 8'h99, got);
        check(got == {1'b0, 7'h33}, "R10 flag clear", got, {1'b0, 7'h33});
        check(rx_data == 8'h99, "R7 data after reset", rx_data, 8'h99);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule